// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block produces the instruction fetch address for a small 8-bit controller. It also saves and restores return state through a stack held in byte-wide data RAM. The 14-bit program counter is split into a low 8-bit offset and an upper 6-bit page number. Sequential advance steps only the offset by the length of the current instruction, and that offset wraps inside its 256-byte page. A separate page strobe bumps the page number, and a jump replaces the whole address.

A call or an interrupt acknowledge saves a 16-bit return frame as two bytes: the carry and zero flags in the top two bits and the 14-bit return address below them. A return pops that frame and reloads the address. Only the interrupt-return variant also hands the stored flags back to the core. Pushes and pops each take two cycles on the RAM port, and the block reports itself busy during those cycles.

The RAM port is a plain memory port, not a stream. The RAM must take a write, or present read data combinationally, in the same cycle the block drives the strobe. There is no back-pressure, so no valid/ready pair exists. The control strobes are sampled only while the block is not busy.

Top module: `pcs_paged_pc`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the block shows pc_o = 0x0000, stack pointer 0x00, busy_o = 0, ram_we_o = ram_re_o = 0, carry_o = zero_o = 0 and flags_ld_o = 0.
- R2: With adv_i high, pc_o[7:0] steps by 1 when two_byte_i = 0 and by 2 when two_byte_i = 1, effective from the next cycle.
- R3: Sequential advance is modulo 256 on pc_o[7:0] and never changes pc_o[13:8]. For example, 0x12FE stepped by 2 gives 0x1200, and 0x12FF stepped by 2 gives 0x1201.
- R4: xpage_i increments pc_o[13:8] modulo 64. When adv_i is high in the same cycle, the offset also steps by the instruction length.
- R5: jump_i loads all 14 bits of target_i into pc_o in the next cycle and overrides adv_i and xpage_i.
- R6: An accepted call saves the frame {carry_i, zero_i, return address}, where the return address is pc_o with the offset stepped by the instruction length (page kept). An accepted interrupt acknowledge saves the same frame with the current pc_o as the return address. In both cases pc_o takes target_i in the next cycle. The low frame byte is written at the stack pointer in the first busy cycle, and the high byte at stack pointer + 1 in the second.
- R7: The stack pointer rises by 2 after a push. A pop first lowers it by 2, modulo 256, then reads the high byte at new pointer + 1 and then the low byte at the new pointer. Reads and writes never occur in the same cycle.
- R8: ret_i reloads pc_o from pop bits [13:0] at the end of the pop. It discards the stored flag bits: carry_o, zero_o stay unchanged and flags_ld_o stays 0.
- R9: reti_i reloads pc_o in the same way and at the same edge sets carry_o = stored bit 15 and zero_o = stored bit 14, with flags_ld_o high for exactly that one cycle.
- R10: busy_o is high for exactly two cycles per push or pop. Strobes presented while busy_o is high are ignored, and pc_o holds until the pop reload.
- R11: Among strobes sampled together while idle the order is interrupt acknowledge, call, reti_i, ret_i, jump_i, then xpage_i/adv_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adv_i | input | 1 | Advance past the current instruction |
| two_byte_i | input | 1 | Instruction length: 0 = one byte, 1 = two bytes |
| xpage_i | input | 1 | Increment the page number |
| jump_i | input | 1 | Load target_i into the program counter |
| call_i | input | 1 | Push return frame and load target_i |
| intack_i | input | 1 | Interrupt acknowledge: push current address and flags, load target_i |
| ret_i | input | 1 | Pop frame, reload address only |
| reti_i | input | 1 | Pop frame, reload address and flags |
| target_i | input | 14 | Jump, call or vector address |
| carry_i | input | 1 | Current carry flag for the frame |
| zero_i | input | 1 | Current zero flag for the frame |
| pc_o | output | 14 | Fetch address |
| busy_o | output | 1 | Push or pop in progress |
| carry_o | output | 1 | Carry flag restored by reti |
| zero_o | output | 1 | Zero flag restored by reti |
| flags_ld_o | output | 1 | One-cycle pulse: carry_o/zero_o were just restored |
| ram_addr_o | output | 8 | Stack RAM byte address |
| ram_wdata_o | output | 8 | Stack RAM write data |
| ram_we_o | output | 1 | Stack RAM write strobe |
| ram_re_o | output | 1 | Stack RAM read strobe |
| ram_rdata_i | input | 8 | Stack RAM read data, valid in the cycle of ram_re_o |

## Verification
The bench builds the block with its defaults: a 14-bit counter, an 8-bit page offset and an 8-bit stack pointer. With these values a single two-byte step already crosses the page boundary, and a page strobe from page 63 reaches the 64-page wrap. A pop straight after reset pulls the pointer below zero to 0xFE, so the pointer wrap is tested without filling 256 bytes of stack.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_LO = 3'd1,
    ST_PUSH_HI = 3'd2,
    ST_POP_HI  = 3'd3,
    ST_POP_LO  = 3'd4
  } stk_state_e;
endpackage

// File: rtl/pcs_pc_core.sv
module pcs_pc_core #(
  parameter int PC_W   = 14,
  parameter int PAGE_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [PC_W-1:0] load_addr_i,
  input  logic            adv_i,
  input  logic            two_byte_i,
  input  logic            xpage_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] next_seq_o
);
  localparam int UP_W = PC_W - PAGE_W;

  logic [PAGE_W-1:0] off_q, off_step;
  logic [UP_W-1:0]   page_q;

  assign off_step   = off_q + (two_byte_i ? PAGE_W'(2) : PAGE_W'(1));
  assign next_seq_o = {page_q, off_step};
  assign pc_o       = {page_q, off_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= '0;
      page_q <= '0;
    end else if (load_i) begin
      off_q  <= load_addr_i[PAGE_W-1:0];
      page_q <= load_addr_i[PC_W-1:PAGE_W];
    end else begin
      if (adv_i)   off_q  <= off_step;
      if (xpage_i) page_q <= page_q + UP_W'(1);
    end
  end

  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> pc_o == $past(load_addr_i)); // R5
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !xpage_i) |=> pc_o[PC_W-1:PAGE_W] == $past(pc_o[PC_W-1:PAGE_W])); // R3
  AST_XPAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && xpage_i) |=> pc_o[PC_W-1:PAGE_W] == $past(pc_o[PC_W-1:PAGE_W]) + UP_W'(1)); // R4
endmodule

// File: rtl/pcs_stack_ptr.sv
module pcs_stack_ptr #(
  parameter int SP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_done_i,
  input  logic            pop_start_i,
  output logic [SP_W-1:0] sp_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)           sp_o <= '0;
    else if (push_done_i) sp_o <= sp_o + SP_W'(2);
    else if (pop_start_i) sp_o <= sp_o - SP_W'(2);
  end

  AST_SP_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    push_done_i |=> sp_o == $past(sp_o) + SP_W'(2)); // R7
  AST_SP_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_start_i && !push_done_i) |=> sp_o == $past(sp_o) - SP_W'(2)); // R7
endmodule

// File: rtl/pcs_frame_fsm.sv
module pcs_frame_fsm
  import pcs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SP_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req_i,
  input  logic              pop_req_i,
  input  logic              pop_flags_i,
  input  logic [2*DATA_W-1:0] frame_i,
  input  logic [SP_W-1:0]   sp_i,
  output logic              busy_o,
  output logic              push_done_o,
  output logic              pop_done_o,
  output logic              pop_flags_o,
  output logic [2*DATA_W-1:0] pop_frame_o,
  output logic [SP_W-1:0]   ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              ram_we_o,
  output logic              ram_re_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  stk_state_e          state_q;
  logic [2*DATA_W-1:0] frame_q;
  logic [DATA_W-1:0]   hi_q;
  logic                flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      frame_q <= '0;
      hi_q    <= '0;
      flags_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (push_req_i) begin
            frame_q <= frame_i;
            state_q <= ST_PUSH_LO;
          end else if (pop_req_i) begin
            flags_q <= pop_flags_i;
            state_q <= ST_POP_HI;
          end
        end
        ST_PUSH_LO: state_q <= ST_PUSH_HI;
        ST_PUSH_HI: state_q <= ST_IDLE;
        ST_POP_HI: begin
          hi_q    <= ram_rdata_i;
          state_q <= ST_POP_LO;
        end
        ST_POP_LO: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ram_addr_o  = sp_i;
    ram_wdata_o = frame_q[DATA_W-1:0];
    ram_we_o    = 1'b0;
    ram_re_o    = 1'b0;
    unique case (state_q)
      ST_PUSH_LO: ram_we_o = 1'b1;
      ST_PUSH_HI: begin
        ram_we_o    = 1'b1;
        ram_addr_o  = sp_i + SP_W'(1);
        ram_wdata_o = frame_q[2*DATA_W-1:DATA_W];
      end
      ST_POP_HI: begin
        ram_re_o   = 1'b1;
        ram_addr_o = sp_i + SP_W'(1);
      end
      ST_POP_LO: ram_re_o = 1'b1;
      default: ;
    endcase
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign push_done_o = (state_q == ST_PUSH_HI);
  assign pop_done_o  = (state_q == ST_POP_LO);
  assign pop_flags_o = flags_q;
  assign pop_frame_o = {hi_q, ram_rdata_i};

  AST_BUSY_RISE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |=> busy_o); // R10
  AST_BUSY_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |=> !busy_o); // R10
  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we_o && ram_re_o)); // R7
  AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_o) |=> ram_we_o && ram_addr_o == $past(ram_addr_o) + SP_W'(1)); // R6
  AST_POP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_re_o) |=> ram_re_o && ram_addr_o == $past(ram_addr_o) - SP_W'(1)); // R7
endmodule

// File: rtl/pcs_paged_pc.sv
module pcs_paged_pc #(
  parameter int  PC_W   = 14,
  parameter int  PAGE_W = 8,
  parameter int  SP_W   = 8,
  localparam int DATA_W = (PC_W + 2) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              two_byte_i,
  input  logic              xpage_i,
  input  logic              jump_i,
  input  logic              call_i,
  input  logic              intack_i,
  input  logic              ret_i,
  input  logic              reti_i,
  input  logic [PC_W-1:0]   target_i,
  input  logic              carry_i,
  input  logic              zero_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              busy_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic              flags_ld_o,
  output logic [SP_W-1:0]   ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              ram_we_o,
  output logic              ram_re_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  localparam int FRAME_W = 2 * DATA_W;

  logic              idle, acc_int, acc_call, acc_push, acc_pop, acc_jump, seq_ok;
  logic              pc_load, push_done, pop_done, pop_flags;
  logic [PC_W-1:0]   pc_next_seq, load_addr;
  logic [FRAME_W-1:0] frame_in, pop_frame;
  logic [SP_W-1:0]   sp;

  // Request acceptance in fixed priority order, only while idle.
  assign idle     = !busy_o;
  assign acc_int  = idle && intack_i;
  assign acc_call = idle && call_i && !intack_i;
  assign acc_push = acc_int || acc_call;
  assign acc_pop  = idle && !intack_i && !call_i && (ret_i || reti_i);
  assign acc_jump = idle && jump_i && !intack_i && !call_i && !ret_i && !reti_i;
  assign seq_ok   = idle && !intack_i && !call_i && !ret_i && !reti_i;

  assign pc_load   = acc_push || acc_jump || pop_done;
  assign load_addr = pop_done ? pop_frame[PC_W-1:0] : target_i;
  assign frame_in  = {carry_i, zero_i, (acc_int ? pc_o : pc_next_seq)};

  pcs_pc_core #(.PC_W(PC_W), .PAGE_W(PAGE_W)) u_pc (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (pc_load),
    .load_addr_i (load_addr),
    .adv_i       (seq_ok && adv_i),
    .two_byte_i  (two_byte_i),
    .xpage_i     (seq_ok && xpage_i),
    .pc_o        (pc_o),
    .next_seq_o  (pc_next_seq)
  );

  pcs_stack_ptr #(.SP_W(SP_W)) u_sp (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_done_i (push_done),
    .pop_start_i (acc_pop),
    .sp_o        (sp)
  );

  pcs_frame_fsm #(.DATA_W(DATA_W), .SP_W(SP_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_req_i  (acc_push),
    .pop_req_i   (acc_pop),
    .pop_flags_i (reti_i),
    .frame_i     (frame_in),
    .sp_i        (sp),
    .busy_o      (busy_o),
    .push_done_o (push_done),
    .pop_done_o  (pop_done),
    .pop_flags_o (pop_flags),
    .pop_frame_o (pop_frame),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o),
    .ram_we_o    (ram_we_o),
    .ram_re_o    (ram_re_o),
    .ram_rdata_i (ram_rdata_i)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_o    <= 1'b0;
      zero_o     <= 1'b0;
      flags_ld_o <= 1'b0;
    end else begin
      flags_ld_o <= pop_done && pop_flags;
      if (pop_done && pop_flags) begin
        carry_o <= pop_frame[FRAME_W-1];
        zero_o  <= pop_frame[FRAME_W-2];
      end
    end
  end

  AST_FLAGS_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_ld_o |-> $stable({carry_o, zero_o})); // R8
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    flags_ld_o |=> !flags_ld_o); // R9
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !pop_done) |=> pc_o == $past(pc_o)); // R10
endmodule

// File: tb/pcs_paged_pc_tb.sv
module pcs_paged_pc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv_i = 0, two_byte_i = 0, xpage_i = 0, jump_i = 0;
  logic        call_i = 0, intack_i = 0, ret_i = 0, reti_i = 0;
  logic [13:0] target_i = '0;
  logic        carry_i = 0, zero_i = 0;
  logic [13:0] pc_o;
  logic        busy_o, carry_o, zero_o, flags_ld_o, ram_we_o, ram_re_o;
  logic [7:0]  ram_addr_o, ram_wdata_o, ram_rdata_i;

  logic [7:0]  mem [256];
  logic        tb_wr = 1'b0;
  logic [7:0]  tb_addr = '0, tb_data = '0;
  int          n_tests = 0, n_fail = 0;
  bit          ended = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (ram_we_o)   mem[ram_addr_o] <= ram_wdata_o;
    else if (tb_wr) mem[tb_addr]    <= tb_data;
  end
  assign ram_rdata_i = mem[ram_addr_o];

  pcs_paged_pc u_dut (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .two_byte_i(two_byte_i),
    .xpage_i(xpage_i), .jump_i(jump_i), .call_i(call_i), .intack_i(intack_i),
    .ret_i(ret_i), .reti_i(reti_i), .target_i(target_i), .carry_i(carry_i),
    .zero_i(zero_i), .pc_o(pc_o), .busy_o(busy_o), .carry_o(carry_o),
    .zero_o(zero_o), .flags_ld_o(flags_ld_o), .ram_addr_o(ram_addr_o),
    .ram_wdata_o(ram_wdata_o), .ram_we_o(ram_we_o), .ram_re_o(ram_re_o),
    .ram_rdata_i(ram_rdata_i)
  );

  // {jump, xpage, adv, two_byte, target[13:0], expected pc[13:0]}
  localparam int NV = 13;
  localparam logic [31:0] VEC [NV] = '{
    {4'b0010, 14'h0000, 14'h0001},  // R2 one byte
    {4'b0011, 14'h0000, 14'h0003},  // R2 two bytes
    {4'b1010, 14'h12FE, 14'h12FE},  // R5 jump beats advance
    {4'b0011, 14'h0000, 14'h1200},  // R3 wrap by two
    {4'b1000, 14'h12FF, 14'h12FF},  // R5
    {4'b0011, 14'h0000, 14'h1201},  // R3 wrap past zero
    {4'b0100, 14'h0000, 14'h1301},  // R4 page only
    {4'b0110, 14'h0000, 14'h1402},  // R4 page plus advance
    {4'b1100, 14'h3F80, 14'h3F80},  // R5 jump beats page
    {4'b0100, 14'h0000, 14'h0080},  // R4 page wraps at 64
    {4'b0000, 14'h0000, 14'h0080},  // R2 no strobe holds
    {4'b1000, 14'h2AFF, 14'h2AFF},  // R5
    {4'b0010, 14'h0000, 14'h2A00}   // R3 wrap by one
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    #1;
    chk("R1 pc", 32'(pc_o), 32'h0);
    chk("R1 busy/we/re/ld", {busy_o, ram_we_o, ram_re_o, flags_ld_o}, 0);
    chk("R1 flags", {carry_o, zero_o}, 0);

    foreach (VEC[i]) begin
      {jump_i, xpage_i, adv_i, two_byte_i} = VEC[i][31:28];
      target_i = VEC[i][27:14];
      step();
      chk($sformatf("R2/R3/R4/R5 vector %0d", i), 32'(pc_o), 32'(VEC[i][13:0]));
    end
    {jump_i, xpage_i, adv_i, two_byte_i} = '0;

    // Call from 0x2A00, two-byte call: return 0x2A02, flags C=1 Z=0
    call_i = 1; two_byte_i = 1; carry_i = 1; zero_i = 0; target_i = 14'h0150;
    step();
    call_i = 0; two_byte_i = 0;
    chk("R6 call target", 32'(pc_o), 32'h0150);
    chk("R10 busy push", 32'(busy_o), 1);
    chk("R6 low byte", {ram_we_o, ram_addr_o, ram_wdata_o}, {1'b1, 8'h00, 8'h02});
    adv_i = 1; jump_i = 1; target_i = 14'h0333;  // must be ignored
    step();
    chk("R6 high byte", {ram_we_o, ram_addr_o, ram_wdata_o}, {1'b1, 8'h01, 8'hAA});
    step();
    chk("R10 busy end", 32'(busy_o), 0);
    chk("R10 ignored while busy", 32'(pc_o), 32'h0150);
    adv_i = 0; jump_i = 0;

    // Interrupt wins over call; saves current pc 0x0150, C=0 Z=1
    intack_i = 1; call_i = 1; carry_i = 0; zero_i = 1; target_i = 14'h0008;
    step();
    intack_i = 0; call_i = 0;
    chk("R11 vector taken", 32'(pc_o), 32'h0008);
    chk("R6 int low", {ram_we_o, ram_addr_o, ram_wdata_o}, {1'b1, 8'h02, 8'h50});
    step();
    chk("R6 int high", {ram_we_o, ram_addr_o, ram_wdata_o}, {1'b1, 8'h03, 8'h41});
    step();

    // reti wins over ret
    reti_i = 1; ret_i = 1;
    step();
    reti_i = 0; ret_i = 0;
    chk("R7 pop high addr", {ram_re_o, ram_we_o, ram_addr_o}, {1'b1, 1'b0, 8'h03});
    step();
    chk("R7 pop low addr", {ram_re_o, ram_addr_o}, {1'b1, 8'h02});
    chk("R10 pc holds mid pop", 32'(pc_o), 32'h0008);
    step();
    chk("R9 pc restored", 32'(pc_o), 32'h0150);
    chk("R9 flags restored", {flags_ld_o, carry_o, zero_o}, 3'b101);
    chk("R10 busy end pop", 32'(busy_o), 0);
    step();
    chk("R9 pulse one cycle", 32'(flags_ld_o), 0);

    // Plain return: frame C=1 Z=0 discarded
    ret_i = 1;
    step();
    ret_i = 0;
    chk("R7 ret high addr", 32'(ram_addr_o), 32'h01);
    step();
    step();
    chk("R8 pc restored", 32'(pc_o), 32'h2A02);
    chk("R8 flags kept", {flags_ld_o, carry_o, zero_o}, 3'b001);

    // Preload wrap slots, reset, pop from empty pointer
    tb_wr = 1; tb_addr = 8'hFF; tb_data = 8'hC7;
    step();
    tb_addr = 8'hFE; tb_data = 8'h34;
    step();
    tb_wr = 0;
    rst_n = 0;
    step(); step();
    rst_n = 1;
    #1;
    chk("R1 pc after reset", 32'(pc_o), 32'h0);
    chk("R1 flags after reset", {flags_ld_o, carry_o, zero_o, busy_o}, 0);
    ret_i = 1; jump_i = 1; target_i = 14'h1111;
    step();
    ret_i = 0; jump_i = 0;
    chk("R7 wrap high addr", 32'(ram_addr_o), 32'hFF);
    step();
    chk("R7 wrap low addr", 32'(ram_addr_o), 32'hFE);
    step();
    chk("R11 ret beats jump", 32'(pc_o), 32'h0734);
    chk("R8 ret no flag load", {flags_ld_o, carry_o, zero_o}, 0);

    finish_run();
  end
endmodule